// File: doc/BRIEF.md
# Two-Channel Double-Buffered DAC Command Port

This block is the serial slave front end of a two-channel, 13-bit digital-to-analog converter. A host shifts 16-bit command words into it over a three-wire link: an active-low select, a serial clock and a data line. Each word carries a channel bit, a two-bit operation code and a 13-bit code. The block holds an input (staging) register and a DAC (live) register per channel. A command can stage a code, make a code live at once, or move the staged codes of both channels to the live registers together. The live registers drive parallel outputs for the converter.

A special operation group reuses the channel bit and the top code bits as sub-commands. These update both channels, enter the shutdown state, set a general-purpose output pin, and pick the serial-clock edge that drives the serial output. The serial output repeats the bit stream 16 sampling edges later, so several devices can be chained.

All serial inputs are re-timed into the system clock domain. A serial clock of up to one fifth of the system clock is supported (10 MHz at a 50 MHz system clock). Each serial-clock level must last at least two system clocks.

Top module: `dual_dac_serial_if`

## Requirements
- R1: A frame is 16 bits, most significant bit first: bit 15 is the channel select (0 = channel A, 1 = channel B), bits 14:13 are the operation code, and bits 12:0 are the code with bit 12 arriving first.
- R2: Data is sampled only on rising serial-clock edges while `cs_n` is low. Serial-clock activity while `cs_n` is high changes no register, does not move `dout`, and does not affect the bit count of the next frame.
- R3: A command executes when `cs_n` rises, and only if exactly 16 rising edges were seen since `cs_n` fell. A frame with fewer or more edges changes no register.
- R4: Operation 00 writes the code into the addressed channel's input register and leaves both DAC outputs unchanged.
- R5: Operation 01 writes the code into the addressed channel's input register, then copies both input registers into both DAC registers in the same command.
- R6: Operation 10 writes the code into both the input and the DAC register of the addressed channel and leaves the other channel's DAC output unchanged.
- R7: Operation 11 is a sub-command selected by {bit 15, bit 12, bit 11}. The value 000 copies both input registers into the DAC registers.
- R8: Sub-command 100 sets `user_out` to bit 10 of the frame.
- R9: `dout` presents each sampled bit again 16 rising edges later, so the previous frame leaves MSB first during the next frame. Sub-command 101 selects the edge that drives `dout`: bit 10 = 1 for the rising edge, 0 for the falling edge. Reset selects the falling edge.
- R10: Sub-command 001 sets `shutdown` and leaves both DAC outputs unchanged. Any operation 00, 01 or 10, or sub-command 000, clears it.
- R11: Synchronous reset clears all input and DAC registers, `user_out`, `shutdown` and `dout`.
- R12: Every output reacts on the third rising system-clock edge after the serial input change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| dout | output | 1 | Delayed serial data out |
| dac_a | output | 13 | Channel A live code |
| dac_b | output | 13 | Channel B live code |
| user_out | output | 1 | General-purpose output level |
| shutdown | output | 1 | Shutdown state flag |

## Verification
Two re-timing flops and one register stage lie between any serial pin change and the output it causes, so every result is due on the third system-clock edge after the change. The bench keeps a behavioural model that reacts to each pin change at once. It delays the model's outputs through a three-entry queue and compares them with the design on every falling system-clock edge. The directed checks after each frame wait several idle cycles. The serial-output captures are sampled three cycles after the serial edge that moves `dout`.

// File: rtl/ddsi_pkg.sv
package ddsi_pkg;

    localparam int WORD_W = 16;
    localparam int CODE_W = 13;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        OP_STAGE     = 2'b00,
        OP_STAGE_ALL = 2'b01,
        OP_DIRECT    = 2'b10,
        OP_SPECIAL   = 2'b11
    } op_e;

    // packed MSB first: channel, operation, code
    typedef struct packed {
        logic              chan;
        op_e               op;
        logic [CODE_W-1:0] code;
    } frame_t;

    localparam logic [2:0] SUB_UPDATE = 3'b000;
    localparam logic [2:0] SUB_SLEEP  = 3'b001;
    localparam logic [2:0] SUB_PIN    = 3'b100;
    localparam logic [2:0] SUB_EDGE   = 3'b101;

    function automatic logic [2:0] sub_of(frame_t f);
        return {f.chan, f.code[CODE_W-1:CODE_W-2]};
    endfunction

    function automatic logic arg_of(frame_t f);
        return f.code[CODE_W-3];
    endfunction

endpackage

// File: rtl/ddsi_edge_sync.sv
module ddsi_edge_sync #(
    parameter int         N      = 3,
    parameter int         STAGES = 2,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level
);
    for (genvar i = 0; i < N; i++) begin : g_sig
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= {STAGES{IDLE[i]}};
            else     pipe <= {pipe[STAGES-2:0], async_in[i]};
        end
        assign level[i] = pipe[STAGES-1];
    end
endmodule

// File: rtl/ddsi_shifter.sv
module ddsi_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_low,
    input  logic         cs_fall,
    input  logic         cs_rise,
    input  logic         sck_rise,
    input  logic         sck_fall,
    input  logic         din_s,
    input  logic         out_on_rise,
    output logic [W-1:0] word,
    output logic         commit,
    output logic         dout
);
    localparam int CNT_W = $clog2(W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(W + 1);

    logic [W-1:0]     sr;
    logic [CNT_W-1:0] cnt;
    logic             tap;
    logic             take;

    assign take   = cs_low && sck_rise;
    assign word   = sr;
    assign commit = cs_rise && (cnt == CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            cnt  <= '0;
            tap  <= 1'b0;
            dout <= 1'b0;
        end else begin
            if (cs_fall)
                cnt <= '0;
            else if (take && cnt != CNT_OVER)
                cnt <= cnt + 1'b1;
            if (take) begin
                sr  <= {sr[W-2:0], din_s};
                tap <= sr[W-1];
                if (out_on_rise) dout <= sr[W-1];
            end
            if (cs_low && sck_fall && !out_on_rise)
                dout <= tap;
        end
    end

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !cs_low |=> $stable(sr));

endmodule

// File: rtl/ddsi_regbank.sv
module ddsi_regbank
    import ddsi_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 commit,
    input  frame_t               cmd,
    output logic [NUM_CH*CW-1:0] dac_flat,
    output logic                 user_out,
    output logic                 shutdown,
    output logic                 out_on_rise
);
    logic [2:0] sub;
    logic       special;
    logic       upd_all;

    assign sub     = sub_of(cmd);
    assign special = (cmd.op == OP_SPECIAL);
    assign upd_all = commit && ((cmd.op == OP_STAGE_ALL) ||
                                (special && sub == SUB_UPDATE));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [CW-1:0] stage_r;
        logic [CW-1:0] live_r;
        logic          hit;
        assign hit = commit && !special && (cmd.chan == 1'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_r <= '0;
                live_r  <= '0;
            end else begin
                if (hit) stage_r <= cmd.code;
                if (hit && cmd.op == OP_DIRECT) live_r <= cmd.code;
                else if (upd_all)               live_r <= hit ? cmd.code : stage_r;
            end
        end
        assign dac_flat[g*CW +: CW] = live_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            user_out    <= 1'b0;
            shutdown    <= 1'b0;
            out_on_rise <= 1'b0;
        end else if (commit) begin
            if (special && sub == SUB_PIN)  user_out    <= arg_of(cmd);
            if (special && sub == SUB_EDGE) out_on_rise <= arg_of(cmd);
            if (special && sub == SUB_SLEEP)
                shutdown <= 1'b1;
            else if (!special || sub == SUB_UPDATE)
                shutdown <= 1'b0;
        end
    end

    assert_dac_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(dac_flat));

    assert_pin_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(user_out));

    assert_sleep_set_R10: assert property (@(posedge clk) disable iff (rst)
        (commit && special && sub == SUB_SLEEP) |=> (shutdown && $stable(dac_flat)));

    assert_direct_a_R6: assert property (@(posedge clk) disable iff (rst)
        (commit && cmd.op == OP_DIRECT && !cmd.chan) |=> (dac_flat[CW-1:0] == $past(cmd.code)));

endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
    import ddsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    output logic [CODE_W-1:0] dac_a,
    output logic [CODE_W-1:0] dac_b,
    output logic              user_out,
    output logic              shutdown
);
    // index 0: select, 1: serial clock, 2: data
    logic [2:0] lvl;
    logic [1:0] prev;
    logic       cs_low, cs_fall, cs_rise, sck_rise, sck_fall;
    logic [WORD_W-1:0] word;
    logic       commit;
    logic       out_on_rise;
    logic [NUM_CH*CODE_W-1:0] dac_flat;

    ddsi_edge_sync #(.N(3), .STAGES(2), .IDLE(3'b001)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({din, sclk, cs_n}),
        .level    (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) prev <= 2'b01;
        else     prev <= lvl[1:0];
    end

    assign cs_low   = !lvl[0];
    assign cs_fall  = !lvl[0] &&  prev[0];
    assign cs_rise  =  lvl[0] && !prev[0];
    assign sck_rise =  lvl[1] && !prev[1];
    assign sck_fall = !lvl[1] &&  prev[1];

    ddsi_shifter #(.W(WORD_W)) i_shift (
        .clk         (clk),
        .rst         (rst),
        .cs_low      (cs_low),
        .cs_fall     (cs_fall),
        .cs_rise     (cs_rise),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .din_s       (lvl[2]),
        .out_on_rise (out_on_rise),
        .word        (word),
        .commit      (commit),
        .dout        (dout)
    );

    ddsi_regbank #(.CW(CODE_W)) i_regs (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .cmd         (frame_t'(word)),
        .dac_flat    (dac_flat),
        .user_out    (user_out),
        .shutdown    (shutdown),
        .out_on_rise (out_on_rise)
    );

    assign dac_a = dac_flat[0 +: CODE_W];
    assign dac_b = dac_flat[CODE_W +: CODE_W];

endmodule

// File: tb/test_dual_dac_serial_if.sv
module test_dual_dac_serial_if;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        dout;
    logic [12:0] dac_a, dac_b;
    logic        user_out, shutdown;

    always #10 clk = ~clk;

    dual_dac_serial_if i_dual_dac_serial_if (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dac_a(dac_a), .dac_b(dac_b),
        .user_out(user_out), .shutdown(shutdown)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [12:0] m_in [2];
    logic [12:0] m_dac [2];
    logic        m_user, m_sd, m_rise, m_dout, m_tap;
    logic [15:0] m_sr;
    int          m_cnt;

    typedef struct {
        logic [12:0] a;
        logic [12:0] b;
        logic        u;
        logic        s;
        logic        d;
    } snap_t;
    snap_t q[$];

    logic        last_dout;
    logic [15:0] cap;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_exec(logic [15:0] w);
        logic       ch;
        logic [1:0] op;
        logic [2:0] sub;
        ch  = w[15];
        op  = w[14:13];
        sub = {w[15], w[12:11]};
        case (op)
            2'b00: begin m_in[ch] = w[12:0]; m_sd = 1'b0; end
            2'b01: begin
                m_in[ch] = w[12:0];
                m_dac[0] = m_in[0];
                m_dac[1] = m_in[1];
                m_sd = 1'b0;
            end
            2'b10: begin m_in[ch] = w[12:0]; m_dac[ch] = w[12:0]; m_sd = 1'b0; end
            default: begin
                case (sub)
                    3'b000: begin m_dac[0] = m_in[0]; m_dac[1] = m_in[1]; m_sd = 1'b0; end
                    3'b001: m_sd = 1'b1;
                    3'b100: m_user = w[10];
                    3'b101: m_rise = w[10];
                    default: ;
                endcase
            end
        endcase
    endtask

    task automatic step(logic c, logic s, logic d);
        snap_t e;
        @(negedge clk);
        last_dout = dout;
        if (q.size() == 3) begin
            e = q.pop_front();
            chk("R12", "dac_a",    32'(dac_a),    32'(e.a));
            chk("R12", "dac_b",    32'(dac_b),    32'(e.b));
            chk("R12", "user_out", 32'(user_out), 32'(e.u));
            chk("R12", "shutdown", 32'(shutdown), 32'(e.s));
            chk("R12", "dout",     32'(dout),     32'(e.d));
        end
        if (!c && s && !sclk) begin
            if (m_cnt < 17) m_cnt++;
            m_tap = m_sr[15];
            if (m_rise) m_dout = m_sr[15];
            m_sr = {m_sr[14:0], d};
        end
        if (!c && !s && sclk && !m_rise) m_dout = m_tap;
        if (!c && cs_n) m_cnt = 0;
        if (c && !cs_n) begin
            if (m_cnt == 16) model_exec(m_sr);
            m_cnt = 0;
        end
        cs_n = c;
        sclk = s;
        din  = d;
        q.push_back('{m_dac[0], m_dac[1], m_user, m_sd, m_dout});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(cs_n, sclk, din);
    endtask

    // shifts the low n bits of bits, MSB first; cap gets dout per bit
    task automatic send(logic [31:0] bits, int n);
        logic b;
        cap = '0;
        step(1'b0, 1'b0, din);
        idle(2);
        for (int k = 0; k < n; k++) begin
            b = bits[n-1-k];
            step(1'b0, 1'b0, b);
            step(1'b0, 1'b0, b);
            step(1'b0, 1'b0, b);
            step(1'b0, 1'b1, b);
            if (k > 0 && k <= 16) cap[16-k] = last_dout;
            step(1'b0, 1'b1, b);
            step(1'b0, 1'b1, b);
        end
        step(1'b0, 1'b0, din);
        idle(2);
        step(1'b1, 1'b0, din);
        cap[0] = last_dout;
        idle(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic d_before;
        m_in[0] = '0; m_in[1] = '0; m_dac[0] = '0; m_dac[1] = '0;
        m_user = 0; m_sd = 0; m_rise = 0; m_dout = 0; m_tap = 0;
        m_sr = '0; m_cnt = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) q.push_back('{13'h0, 13'h0, 1'b0, 1'b0, 1'b0});

        // R11: reset state
        chk("R11", "dac_a",    32'(dac_a),    0);
        chk("R11", "dac_b",    32'(dac_b),    0);
        chk("R11", "user_out", 32'(user_out), 0);
        chk("R11", "shutdown", 32'(shutdown), 0);
        chk("R11", "dout",     32'(dout),     0);
        idle(3);

        // R4: stage only on channel A
        send(32'h1234, 16);
        chk("R4", "dac_a", 32'(dac_a), 0);
        chk("R4", "dac_b", 32'(dac_b), 0);

        // R7: update both from staging; R9: falling-edge output of previous frame
        send(32'h6000, 16);
        chk("R7", "dac_a", 32'(dac_a), 32'h1234);
        chk("R7", "dac_b", 32'(dac_b), 0);
        chk("R9", "dout falling-edge stream", 32'(cap), 32'h1234);

        // R6: direct write to channel B
        send(32'hCABC, 16);
        chk("R6", "dac_b", 32'(dac_b), 32'h0ABC);
        chk("R6", "dac_a", 32'(dac_a), 32'h1234);

        // R4 then R5
        send(32'h9111, 16);
        chk("R4", "dac_b", 32'(dac_b), 32'h0ABC);
        send(32'h2F0F, 16);
        chk("R5", "dac_a", 32'(dac_a), 32'h0F0F);
        chk("R5", "dac_b", 32'(dac_b), 32'h1111);

        // R3: short and long frames discarded
        send(32'h5FFF, 15);
        chk("R3", "dac_a after 15 bits", 32'(dac_a), 32'h0F0F);
        send(32'h05FFF, 17);
        chk("R3", "dac_a after 17 bits", 32'(dac_a), 32'h0F0F);

        // R2: serial clock with select high is ignored
        d_before = dout;
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b1, 1'b1); idle(2);
            step(1'b1, 1'b0, 1'b1); idle(2);
        end
        chk("R2", "dout while idle", 32'(dout), 32'(d_before));
        chk("R2", "dac_a while idle", 32'(dac_a), 32'h0F0F);
        send(32'h4555, 16);
        chk("R2", "dac_a after idle clocks", 32'(dac_a), 32'h0555);

        // R1: bit order, channel B direct with code 1
        send(32'hC001, 16);
        chk("R1", "dac_b", 32'(dac_b), 32'h0001);
        chk("R1", "dac_a", 32'(dac_a), 32'h0555);

        // R8: user pin
        send(32'hE400, 16);
        chk("R8", "user_out high", 32'(user_out), 1);
        send(32'hE000, 16);
        chk("R8", "user_out low", 32'(user_out), 0);

        // R10: shutdown entry and exit
        send(32'h6800, 16);
        chk("R10", "shutdown set", 32'(shutdown), 1);
        chk("R10", "dac_a kept", 32'(dac_a), 32'h0555);
        send(32'h6000, 16);
        chk("R10", "shutdown cleared", 32'(shutdown), 0);

        // R9: rising-edge output mode
        send(32'hEC00, 16);
        send(32'h1ABC, 16);
        chk("R9", "dout rising-edge stream", 32'(cap), 32'hEC00);
        send(32'h0000, 16);
        chk("R9", "dout next frame", 32'(cap), 32'h1ABC);

        idle(6);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule